// File: doc/BRIEF.md
# Double-Buffered Serial Peripheral Master

The block is a byte-wide serial peripheral master attached to a small register port. Software writes a byte into a transmit holding register; as soon as the shift engine is free the byte moves into it and leaves on the data output, most significant bit first, while the same number of bits arrive on the data input. When the eighth bit completes, the received byte is copied into a receive holding register. Because both directions have a holding stage, software can queue a second byte while the first is still on the wire, and the engine runs the two bytes back to back.

Two interrupt flags, transmit-ready and receive-ready, clear themselves when software touches the matching holding register, so the driver never has to clear them by hand and cannot lose an event that way. A sticky overrun bit records that a received byte replaced one that was never read. The serial clock is the module clock divided by an even factor set in a control register; the smallest setting gives half the module clock.

Top module: `spi_dbuf_master`

## Requirements
- R1: After reset the status register reads 0x01 (only transmit-ready set), the control register reads 0, the serial clock and data output are low, the transmit interrupt is high and the receive interrupt is low.
- R2: Writing the transmit register (address 2) clears transmit-ready on that edge; if the engine is idle the byte enters it on the next edge, where transmit-ready sets again.
- R3: The serial clock idles low; each byte goes out most significant bit first, the data output changes only when the clock falls and stays stable while it is high, and the input is sampled on the rising clock.
- R4: With divider field value d (control register bits 3:0) each half period of the serial clock lasts d+1 module cycles, so d=0 divides by 2, and a byte completes 16*(d+1) cycles after it enters the engine.
- R5: At the end of each byte the received byte is placed in the receive register (address 3) and receive-ready sets; reading the receive register clears receive-ready.
- R6: A byte written while another is shifting is started on the completion edge of the first, with no idle cycle between the bytes.
- R7: If a byte completes while receive-ready is still set and no receive read happens on that edge, overrun (status bit 2) sets and the newer byte replaces the old one.
- R8: Overrun stays set until a status read (taken while it is set) is followed by a receive-register read, or until 0 is written to status bit 2; a receive read with no preceding status read leaves it set.
- R9: Writing the status register (address 1) with 0 in bit 0, 1 or 2 clears transmit-ready, receive-ready or overrun; a 1 has no effect; a flag-set event on the same edge as such a clear wins.
- R10: Status bit 3 (busy) is high while the shift engine holds a byte that has not fully shifted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Module clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| sel_i | input | 1 | Register access strobe, one access per cycle |
| we_i | input | 1 | 1 for write, 0 for read |
| addr_i | input | 2 | Register address: 0 control, 1 status, 2 transmit, 3 receive |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Read data for addr_i, combinational |
| tx_irq_o | output | 1 | Transmit-ready flag |
| rx_irq_o | output | 1 | Receive-ready flag |
| sclk_o | output | 1 | Serial clock |
| mosi_o | output | 1 | Serial data out |
| miso_i | input | 1 | Serial data in |

## Verification
A bench slave model returns a different arithmetic byte on every transfer while recording the bits it receives, so each transmit and receive byte is compared to an independent value. Single bytes are swept over four divider settings with several data values, which separates divider, timing and bit-order faults. Bytes queued back to back with no read in between tell correct double buffering and overrun from a single-buffered engine, and the status reads and writes placed around them separate the two overrun clearing paths and the set-over-clear priority on an exact edge.

// File: rtl/spi_dbuf_pkg.sv
package spi_dbuf_pkg;
  typedef enum logic [1:0] {
    REG_CTRL  = 2'd0,
    REG_STAT  = 2'd1,
    REG_TXBUF = 2'd2,
    REG_RXBUF = 2'd3
  } reg_addr_e;

  localparam int unsigned ST_TXRDY = 0;
  localparam int unsigned ST_RXRDY = 1;
  localparam int unsigned ST_OVR   = 2;
  localparam int unsigned ST_BUSY  = 3;
endpackage

// File: rtl/spi_clk_div.sv
module spi_clk_div #(
  parameter int unsigned DIV_W = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             run_i,
  input  logic [DIV_W-1:0] div_i,
  output logic             tick_o
);
  logic [DIV_W-1:0] cnt_q;

  assign tick_o = run_i && (cnt_q == div_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)         cnt_q <= '0;
    else if (!run_i)     cnt_q <= '0;
    else if (tick_o)     cnt_q <= '0;
    else                 cnt_q <= cnt_q + 1'b1;
  end

  a_r4_tick_bound: assert property (@(posedge clk_i) disable iff (!rst_ni)
    run_i |-> (cnt_q <= div_i));
endmodule

// File: rtl/spi_shift_eng.sv
module spi_shift_eng #(
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_i,
  input  logic [DATA_W-1:0] load_data_i,
  input  logic              tick_i,
  input  logic              miso_i,
  output logic              busy_o,
  output logic              done_o,
  output logic [DATA_W-1:0] rx_data_o,
  output logic              sclk_o,
  output logic              mosi_o
);
  localparam int unsigned BW = (DATA_W > 1) ? $clog2(DATA_W) : 1;
  localparam logic [BW-1:0] LAST = BW'(DATA_W - 1);

  logic              active_q, sclk_q;
  logic [BW-1:0]     bit_q;
  logic [DATA_W-1:0] tx_sh_q, rx_sh_q;

  // completion on the falling edge after the last sample
  assign done_o    = active_q && tick_i && sclk_q && (bit_q == LAST);
  assign busy_o    = active_q;
  assign rx_data_o = rx_sh_q;
  assign sclk_o    = sclk_q;
  assign mosi_o    = active_q ? tx_sh_q[DATA_W-1] : 1'b0;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      active_q <= 1'b0;
      sclk_q   <= 1'b0;
      bit_q    <= '0;
      tx_sh_q  <= '0;
      rx_sh_q  <= '0;
    end else if (load_i) begin
      active_q <= 1'b1;
      sclk_q   <= 1'b0;
      bit_q    <= '0;
      tx_sh_q  <= load_data_i;
    end else if (active_q && tick_i) begin
      if (!sclk_q) begin
        sclk_q  <= 1'b1;
        rx_sh_q <= {rx_sh_q[DATA_W-2:0], miso_i};
      end else begin
        sclk_q <= 1'b0;
        if (bit_q == LAST) begin
          active_q <= 1'b0;
        end else begin
          bit_q   <= bit_q + 1'b1;
          tx_sh_q <= {tx_sh_q[DATA_W-2:0], 1'b0};
        end
      end
    end
  end

  a_r3_sclk_idle_low: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o |-> !sclk_o);
  a_r3_mosi_hold_high: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sclk_o && $past(sclk_o)) |-> $stable(mosi_o));
  a_r10_done_while_busy: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> (!busy_o || $past(load_i)));
endmodule

// File: rtl/spi_dbuf_regs.sv
module spi_dbuf_regs
  import spi_dbuf_pkg::*;
#(
  parameter int unsigned DATA_W = 8,
  parameter int unsigned DIV_W  = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              sel_i,
  input  logic              we_i,
  input  logic [1:0]        addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic [DIV_W-1:0]  div_o,
  output logic              load_o,
  output logic [DATA_W-1:0] load_data_o,
  input  logic              eng_busy_i,
  input  logic              eng_done_i,
  input  logic [DATA_W-1:0] eng_rx_i,
  output logic              tx_ready_o,
  output logic              rx_ready_o
);
  logic              ctrl_wr, stat_wr, stat_rd, tx_wr, rx_rd;
  logic [DIV_W-1:0]  div_q;
  logic              hold_v_q, tx_rdy_q, rx_rdy_q, ovr_q, armed_q;
  logic [DATA_W-1:0] hold_q, rx_buf_q;
  logic              ovr_set;

  assign ctrl_wr = sel_i &&  we_i && (addr_i == REG_CTRL);
  assign stat_wr = sel_i &&  we_i && (addr_i == REG_STAT);
  assign stat_rd = sel_i && !we_i && (addr_i == REG_STAT);
  assign tx_wr   = sel_i &&  we_i && (addr_i == REG_TXBUF);
  assign rx_rd   = sel_i && !we_i && (addr_i == REG_RXBUF);

  assign load_o      = hold_v_q && (!eng_busy_i || eng_done_i);
  assign load_data_o = hold_q;
  assign div_o       = div_q;
  assign tx_ready_o  = tx_rdy_q;
  assign rx_ready_o  = rx_rdy_q;
  assign ovr_set     = eng_done_i && rx_rdy_q && !rx_rd;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) div_q <= '0;
    else if (ctrl_wr) div_q <= wdata_i[DIV_W-1:0];
  end

  // transmit holding stage; a write on the load edge refills it
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hold_v_q <= 1'b0;
      hold_q   <= '0;
      tx_rdy_q <= 1'b1;
    end else begin
      if (load_o) hold_v_q <= 1'b0;
      if (tx_wr) begin
        hold_v_q <= 1'b1;
        hold_q   <= wdata_i;
      end
      if (tx_wr)                            tx_rdy_q <= 1'b0;
      else if (load_o)                      tx_rdy_q <= 1'b1;
      else if (stat_wr && !wdata_i[ST_TXRDY]) tx_rdy_q <= 1'b0;
    end
  end

  // receive holding stage and sticky overrun
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rx_buf_q <= '0;
      rx_rdy_q <= 1'b0;
      ovr_q    <= 1'b0;
      armed_q  <= 1'b0;
    end else begin
      if (eng_done_i) rx_buf_q <= eng_rx_i;
      if (eng_done_i)                          rx_rdy_q <= 1'b1;
      else if (rx_rd)                          rx_rdy_q <= 1'b0;
      else if (stat_wr && !wdata_i[ST_RXRDY])  rx_rdy_q <= 1'b0;
      if (ovr_set)                             ovr_q <= 1'b1;
      else if (rx_rd && armed_q)               ovr_q <= 1'b0;
      else if (stat_wr && !wdata_i[ST_OVR])    ovr_q <= 1'b0;
      if (stat_rd && ovr_q)                    armed_q <= 1'b1;
      else if (rx_rd || !ovr_q)                armed_q <= 1'b0;
    end
  end

  always_comb begin
    rdata_o = '0;
    unique case (addr_i)
      REG_CTRL:  rdata_o[DIV_W-1:0] = div_q;
      REG_STAT: begin
        rdata_o[ST_TXRDY] = tx_rdy_q;
        rdata_o[ST_RXRDY] = rx_rdy_q;
        rdata_o[ST_OVR]   = ovr_q;
        rdata_o[ST_BUSY]  = eng_busy_i;
      end
      REG_TXBUF: rdata_o = '0;
      default:   rdata_o = rx_buf_q;
    endcase
  end

  a_r2_txwr_clears_ready: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_wr |=> !tx_ready_o);
  a_r2_load_sets_ready: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (load_o && !tx_wr) |=> tx_ready_o);
  a_r5_done_sets_rx: assert property (@(posedge clk_i) disable iff (!rst_ni)
    eng_done_i |=> rx_ready_o);
  a_r7_overrun_sets: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (eng_done_i && rx_ready_o && !rx_rd) |=> ovr_q);
  a_r8_overrun_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ovr_q && !rx_rd && !stat_wr) |=> ovr_q);
  a_r6_no_idle_gap: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (eng_done_i && hold_v_q) |-> load_o);
endmodule

// File: rtl/spi_dbuf_master.sv
module spi_dbuf_master #(
  parameter int unsigned DATA_W = 8,
  parameter int unsigned DIV_W  = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              sel_i,
  input  logic              we_i,
  input  logic [1:0]        addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic              tx_irq_o,
  output logic              rx_irq_o,
  output logic              sclk_o,
  output logic              mosi_o,
  input  logic              miso_i
);
  logic [DIV_W-1:0]  div;
  logic              load, busy, done, tick;
  logic [DATA_W-1:0] load_data, rx_data;

  spi_dbuf_regs #(.DATA_W(DATA_W), .DIV_W(DIV_W)) u_regs (
    .clk_i, .rst_ni, .sel_i, .we_i, .addr_i, .wdata_i, .rdata_o,
    .div_o(div), .load_o(load), .load_data_o(load_data),
    .eng_busy_i(busy), .eng_done_i(done), .eng_rx_i(rx_data),
    .tx_ready_o(tx_irq_o), .rx_ready_o(rx_irq_o)
  );

  spi_clk_div #(.DIV_W(DIV_W)) u_div (
    .clk_i, .rst_ni, .run_i(busy), .div_i(div), .tick_o(tick)
  );

  spi_shift_eng #(.DATA_W(DATA_W)) u_eng (
    .clk_i, .rst_ni, .load_i(load), .load_data_i(load_data), .tick_i(tick),
    .miso_i, .busy_o(busy), .done_o(done), .rx_data_o(rx_data),
    .sclk_o, .mosi_o
  );

  a_r1_sclk_low_in_reset: assert property (@(posedge clk_i)
    !rst_ni |-> !sclk_o);
endmodule

// File: tb/spi_dbuf_master_tb.sv
`timescale 1ns/1ps
module spi_dbuf_master_tb;
  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  always #2.5 clk = ~clk;

  logic       sel = 0, we = 0;
  logic [1:0] addr = 0;
  logic [7:0] wdata = 0;
  logic [7:0] rdata;
  logic       tx_irq, rx_irq, sclk, mosi, miso;

  spi_dbuf_master u_dut (
    .clk_i(clk), .rst_ni(rst_ni), .sel_i(sel), .we_i(we), .addr_i(addr),
    .wdata_i(wdata), .rdata_o(rdata), .tx_irq_o(tx_irq), .rx_irq_o(rx_irq),
    .sclk_o(sclk), .mosi_o(mosi), .miso_i(miso)
  );

  int tests = 0, fails = 0, wd = 0;

  function automatic int cyc_now();
    return int'($floor($realtime / 5.0));
  endfunction

  function automatic logic [7:0] pat(input int k);
    return 8'((k * 53 + 60) & 255);
  endfunction

  // slave model
  logic [7:0] s_tx, s_rx = 0;
  int s_bits = 0, cap_n = 0, last_rise = 0, mode_err = 0;
  logic [7:0] cap_byte [0:63];
  int cap_cyc [0:63];
  int rise_gap [0:63];
  logic mosi_at_rise = 0;
  initial s_tx = pat(0);
  assign miso = s_tx[7];

  always @(posedge sclk) begin
    s_rx = {s_rx[6:0], mosi};
    mosi_at_rise = mosi;
    if (s_bits == 1) rise_gap[cap_n] = cyc_now() - last_rise;
    last_rise = cyc_now();
    s_bits++;
  end
  always @(negedge sclk) begin
    if (s_bits == 8) begin
      cap_byte[cap_n] = s_rx;
      cap_cyc[cap_n] = cyc_now();
      cap_n++;
      s_tx = pat(cap_n);
      s_bits = 0;
    end else s_tx = {s_tx[6:0], 1'b0};
  end
  always @(negedge clk) if (rst_ni && sclk && mosi !== mosi_at_rise) mode_err++;

  task automatic chk(input string req, input int act, input int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic bw(input logic [1:0] a, input logic [7:0] d, output int stamp);
    @(negedge clk); sel = 1; we = 1; addr = a; wdata = d;
    @(posedge clk); #1; stamp = cyc_now(); sel = 0; we = 0;
  endtask

  task automatic br(input logic [1:0] a, output logic [7:0] d);
    @(negedge clk); sel = 1; we = 0; addr = a;
    #1 d = rdata;
    @(posedge clk); #1 sel = 0;
  endtask

  task automatic wait_cap(input int n);
    while (cap_n < n) @(negedge clk);
    @(negedge clk);
  endtask

  always @(posedge clk) begin
    wd++;
    if (wd > 100000) begin
      tests++; fails++;
      $display("FAIL watchdog: actual %0d expected below 100000", wd);
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    int w, s, k;
    logic [7:0] v, b;
    repeat (3) @(negedge clk);
    rst_ni = 1;
    // R1 reset state
    br(2'd1, v); chk("R1 status", v, 8'h01);
    br(2'd0, v); chk("R1 ctrl", v, 0);
    chk("R1 sclk", sclk, 0); chk("R1 mosi", mosi, 0);
    chk("R1 tx_irq", tx_irq, 1); chk("R1 rx_irq", rx_irq, 0);

    // divider and data sweep
    for (int d = 0; d < 4; d++) begin
      bw(2'd0, 8'(d), w);
      br(2'd0, v); chk("R4 ctrl readback", v, d);
      for (int j = 0; j < 4; j++) begin
        k = cap_n;
        b = 8'((d * 64 + j * 29 + 8'h5A) & 255);
        bw(2'd2, b, w);
        chk("R2 tx_ready cleared by write", tx_irq, 0);
        @(posedge clk); #1;
        chk("R2 tx_ready set at load", tx_irq, 1);
        if (j == 0) begin
          br(2'd1, v); chk("R10 busy while shifting", v, 8'h09);
        end
        wait_cap(k + 1);
        chk("R3 slave received byte", cap_byte[k], b);
        chk("R4 byte duration", cap_cyc[k] - w, 1 + 16 * (d + 1));
        chk("R4 sclk period", rise_gap[k], 2 * (d + 1));
        chk("R5 rx_ready set", rx_irq, 1);
        if (j == 1) begin
          br(2'd1, v); chk("R10 busy clear when idle", v, 8'h03);
        end
        br(2'd3, v); chk("R5 rx data", v, pat(k));
        chk("R5 rx_ready cleared by read", rx_irq, 0);
      end
    end

    // back to back with overrun, d=0
    bw(2'd0, 8'd0, w);
    k = cap_n;
    bw(2'd2, 8'hC3, w);
    while (!tx_irq) @(negedge clk);
    bw(2'd2, 8'h3C, w);
    chk("R6 second write during shift", cap_n, k);
    wait_cap(k + 2);
    chk("R6 first byte", cap_byte[k], 8'hC3);
    chk("R6 second byte", cap_byte[k + 1], 8'h3C);
    chk("R6 no idle gap", cap_cyc[k + 1] - cap_cyc[k], 16);
    br(2'd3, v); chk("R7 newer byte kept", v, pat(k + 1));
    br(2'd1, v); chk("R8 rx read alone keeps overrun", v, 8'h05);
    br(2'd3, v);
    br(2'd1, v); chk("R8 status then rx read clears", v, 8'h01);

    // overrun cleared by writing zero, d=1
    bw(2'd0, 8'd1, w);
    k = cap_n;
    bw(2'd2, 8'hA5, w);
    while (!tx_irq) @(negedge clk);
    bw(2'd2, 8'h5A, w);
    wait_cap(k + 2);
    chk("R6 no idle gap d=1", cap_cyc[k + 1] - cap_cyc[k], 32);
    chk("R7 overrun seen at port", rx_irq, 1);
    bw(2'd1, 8'hFB, w);
    br(2'd1, v); chk("R8 zero write clears overrun", v, 8'h03);
    bw(2'd1, 8'hFF, w);
    br(2'd1, v); chk("R9 writing ones no effect", v, 8'h03);
    bw(2'd1, 8'hFD, w);
    br(2'd1, v); chk("R9 zero write clears rx_ready", v, 8'h01);
    bw(2'd1, 8'hFE, w);
    chk("R9 zero write clears tx_ready", tx_irq, 0);

    // set wins over explicit clear on the completion edge, d=1
    k = cap_n;
    bw(2'd2, 8'h77, w);
    repeat (32) @(posedge clk);
    bw(2'd1, 8'h01, s);
    chk("R9 clear lands on completion edge", s - w, 33);
    chk("R9 set wins over clear", rx_irq, 1);
    br(2'd3, v); chk("R5 rx data after race", v, pat(k));
    chk("R3 slave byte after race", cap_byte[k], 8'h77);

    repeat (4) @(negedge clk);
    chk("R3 sclk idles low", sclk, 0);
    chk("R3 mosi stable while sclk high", mode_err, 0);

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule